// File: doc/BRIEF.md
# Triangle-Capable Dual-Output Pulse-Width Modulator

This block produces two pulse-width modulated outputs, A and B, from one shared time base. A 16-bit counter advances on ticks from a prescaler built from two cascaded power-of-two dividers. The counter either saw-tooths from zero to the period value and wraps, or runs as a triangle, climbing to the period value and falling back to zero. Each output owns a compare register and an action qualifier. When the counter meets the compare value, the qualifier sets, clears, toggles or leaves its output. A separate action is held for the rising slope and for the falling slope. In triangle mode, this lets output A be set on the way up and cleared on the way down. Output B can take the mirror actions, which gives centre-aligned complementary waveforms.

Software writes compare values into shadow copies. By default the live compare value is refreshed from the shadow only on a tick at which the counter stands at zero, so a duty change never splits a pulse. A per-channel mode bit switches a channel to immediate loading. Registers are written through a simple single-cycle write port.

Register map: address 0 holds the period, of which only the low 16 bits of a write are kept. Address 1 is compare A and address 2 is compare B. Address 3 is control: bit 0 selects triangle mode when 1, bits 3:1 hold the first divider exponent, bits 6:4 hold the second divider exponent, bit 7 selects immediate load for A and bit 8 selects immediate load for B. Addresses 4 and 5 are the action fields for A and B. In each of them, bits 1:0 act on a rising-slope match and bits 3:2 act on a falling-slope match.

The time-base state machine has two states, COUNT_UP and COUNT_DOWN. It goes from COUNT_UP to COUNT_DOWN on a tick at which the counter has reached the period. It goes from COUNT_DOWN to COUNT_UP on a tick at which the counter is zero. In saw-tooth mode it is held in COUNT_UP.

Top module: `pwm_updown_top`

## Requirements
- R1: After reset both outputs are low, every register is zero and the counter stands at zero.
- R2: In saw-tooth mode (control bit 0 = 0) the counter steps 0,1,…,P and then wraps to 0, so one period lasts P+1 ticks.
- R3: In triangle mode (control bit 0 = 1) the counter climbs from 0 to P and descends back to 0, so one period lasts 2·P ticks.
- R4: A counter tick occurs once every 2^h · 2^g clocks, where h is control bits 3:1 and g is control bits 6:4.
- R5: A period write keeps only the low 16 bits of the data word; for example, 0x0001_0007 gives a period of 7.
- R6: In shadowed mode a compare write reaches the live compare value only on a tick at which the counter is zero.
- R7: With a channel's immediate bit set (bit 7 for A, bit 8 for B), a compare write reaches the live value on the next clock.
- R8: Action codes are 00 = no action, 01 = drive low, 10 = drive high and 11 = invert. The output changes on the clock edge of the tick at which the counter equals the live compare value.
- R9: The rising-slope action (field bits 1:0) and the falling-slope action (field bits 3:2) are separate. In triangle mode, with A set on rise and cleared on fall, A is high for 2·(P−C) ticks. B with the mirror actions and the same compare is its exact complement.
- R10: In triangle mode a compare value of 0 or P matches once per period. Only the rising-slope action applies at 0, and only the falling-slope action applies at P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |

## Verification
The rising-slope and falling-slope qualifiers of one channel can both claim the same tick at the turning points of the triangle. With a compare of 0 or of P, the counter reaches that value exactly once per period. If both actions applied there, a toggle would cancel or a second edge would appear. The bench provokes this by programming the invert code for both slopes, with a compare of 0 and then with a compare of P. It requires exactly one inversion every 2·P clocks. A second coincidence is a compare write landing while a pulse is in progress. It is judged by pulse widths: the current pulse must keep its old width in shadowed mode and take the new one at once in immediate mode.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_INVERT = 2'b11
    } act_e;

    typedef enum logic {
        COUNT_UP   = 1'b0,
        COUNT_DOWN = 1'b1
    } tb_state_e;

    localparam int unsigned ADR_PERIOD = 0;
    localparam int unsigned ADR_CMP0   = 1;
    localparam int unsigned ADR_CTRL   = 3;
    localparam int unsigned ADR_ACT0   = 4;

    localparam int unsigned CTL_TRI    = 0;
    localparam int unsigned CTL_DIV1_L = 1;
    localparam int unsigned CTL_DIV2_L = 4;
    localparam int unsigned CTL_IMM0   = 7;
    localparam int unsigned CTL_W      = 9;

endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] exp1,
    input  logic [CODE_W-1:0] exp2,
    output logic              tick
);
    localparam int unsigned STG_W = 2 ** CODE_W;

    logic [STG_W-1:0] cnt1, cnt2;
    logic [STG_W-1:0] lim1, lim2;
    logic             tick1;

    always_comb begin
        lim1  = (STG_W'(1) << exp1) - STG_W'(1);
        lim2  = (STG_W'(1) << exp2) - STG_W'(1);
        tick1 = (cnt1 >= lim1);
        tick  = tick1 && (cnt2 >= lim2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt1 <= '0;
            cnt2 <= '0;
        end else begin
            cnt1 <= tick1 ? '0 : cnt1 + STG_W'(1);
            if (tick1) begin
                cnt2 <= (cnt2 >= lim2) ? '0 : cnt2 + STG_W'(1);
            end
        end
    end

    // R4: a divided tick is never followed by another on the next clock
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (exp1 != '0 || exp2 != '0)) |=> !tick);

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             tri_mode,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             slope_up,
    output logic             at_zero
);
    tb_state_e        state_q, state_n;
    logic [CNT_W-1:0] cnt_n;

    // next state and next count
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt;
        if (tick) begin
            if (!tri_mode) begin
                state_n = COUNT_UP;
                cnt_n   = (cnt >= period) ? '0 : cnt + CNT_W'(1);
            end else begin
                unique case (state_q)
                    COUNT_UP: begin
                        if (cnt >= period) begin
                            if (period == '0) begin
                                cnt_n = '0;
                            end else begin
                                state_n = COUNT_DOWN;
                                cnt_n   = cnt - CNT_W'(1);
                            end
                        end else begin
                            cnt_n = cnt + CNT_W'(1);
                        end
                    end
                    COUNT_DOWN: begin
                        if (cnt == '0) begin
                            state_n = COUNT_UP;
                            cnt_n   = (period == '0) ? '0 : CNT_W'(1);
                        end else begin
                            cnt_n = cnt - CNT_W'(1);
                        end
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= COUNT_UP;
            cnt     <= '0;
        end else begin
            state_q <= state_n;
            cnt     <= cnt_n;
        end
    end

    // outputs: slope seen by the qualifiers, turning points decided by value
    always_comb begin
        at_zero = (cnt == '0);
        if (!tri_mode)          slope_up = 1'b1;
        else if (at_zero)       slope_up = 1'b1;
        else if (cnt >= period) slope_up = 1'b0;
        else                    slope_up = (state_q == COUNT_UP);
    end

    // R2: saw-tooth wraps to zero after the period
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !tri_mode && cnt >= period) |=> cnt == '0);

    // R3: on the falling slope the count decreases by one per tick
    p_descend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && tri_mode && state_q == COUNT_DOWN && cnt != '0)
        |=> cnt == $past(cnt) - CNT_W'(1));

    // R4: the count holds between ticks
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             immediate,
    input  logic             tick,
    input  logic             at_zero,
    input  logic [CNT_W-1:0] cnt,
    output logic             hit
);
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] live_q;
    logic             reload;

    assign reload = tick && at_zero;
    assign hit    = tick && (cnt == live_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            live_q   <= '0;
        end else begin
            if (wr) begin
                shadow_q <= wr_val;
            end
            if (wr && (immediate || reload)) begin
                live_q <= wr_val;
            end else if (reload) begin
                live_q <= shadow_q;
            end
        end
    end

    // R6: the live value changes only at a zero reload or an immediate write
    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && !(wr && immediate)) |=> $stable(live_q));

    // R7: an immediate write is visible on the next clock
    p_immediate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && immediate) |=> live_q == $past(wr_val));

endmodule

// File: rtl/pwm_action.sv
module pwm_action
    import pwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_up,
    input  logic ev_dn,
    input  act_e act_up,
    input  act_e act_dn,
    output logic out
);
    act_e sel;
    logic out_n;

    always_comb begin
        sel   = ev_up ? act_up : (ev_dn ? act_dn : ACT_NONE);
        out_n = out;
        unique case (sel)
            ACT_NONE:   out_n = out;
            ACT_LOW:    out_n = 1'b0;
            ACT_HIGH:   out_n = 1'b1;
            ACT_INVERT: out_n = ~out;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out <= 1'b0;
        else        out <= out_n;
    end

    // R8: with no match the output holds
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_up && !ev_dn) |=> $stable(out));

    // R10: a match is never both rising-slope and falling-slope
    p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_up && ev_dn));

endmodule

// File: rtl/pwm_updown_top.sv
module pwm_updown_top
    import pwm_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_a,
    output logic              pwm_b
);
    localparam int unsigned NCH = 2;

    logic [CNT_W-1:0]  period_q;
    logic [CTL_W-1:0]  ctrl_q;
    logic [3:0]        act_q [NCH];
    logic              tick, slope_up, at_zero;
    logic [CNT_W-1:0]  cnt;
    logic [NCH-1:0]    outs;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '0;
            ctrl_q   <= '0;
            for (int i = 0; i < NCH; i++) act_q[i] <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_PERIOD)) period_q <= wr_data[CNT_W-1:0];
            if (wr_addr == ADDR_W'(ADR_CTRL))   ctrl_q   <= wr_data[CTL_W-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == ADDR_W'(ADR_ACT0 + i)) act_q[i] <= wr_data[3:0];
            end
        end
    end

    pwm_prescale #(.CODE_W(CODE_W)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .exp1 (ctrl_q[CTL_DIV1_L +: CODE_W]),
        .exp2 (ctrl_q[CTL_DIV2_L +: CODE_W]),
        .tick (tick)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .tri_mode(ctrl_q[CTL_TRI]),
        .period  (period_q),
        .cnt     (cnt),
        .slope_up(slope_up),
        .at_zero (at_zero)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic hit;

        pwm_compare #(.CNT_W(CNT_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (wr_en && wr_addr == ADDR_W'(ADR_CMP0 + ch)),
            .wr_val   (wr_data[CNT_W-1:0]),
            .immediate(ctrl_q[CTL_IMM0 + ch]),
            .tick     (tick),
            .at_zero  (at_zero),
            .cnt      (cnt),
            .hit      (hit)
        );

        pwm_action u_act (
            .clk   (clk),
            .rst_n (rst_n),
            .ev_up (hit && slope_up),
            .ev_dn (hit && !slope_up),
            .act_up(act_e'(act_q[ch][1:0])),
            .act_dn(act_e'(act_q[ch][3:2])),
            .out   (outs[ch])
        );
    end

    assign pwm_a = outs[0];
    assign pwm_b = outs[1];

    // R1: outputs are low on the first clock after reset
    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> (!pwm_a && !pwm_b));

endmodule

// File: tb/sim_pwm_updown_top.sv
module sim_pwm_updown_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pwm_a, pwm_b;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_updown_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input int adr, input int dat);
        wr_en   = 1'b1;
        wr_addr = 3'(adr);
        wr_data = 32'(dat);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    function automatic logic pick(input bit b);
        return b ? pwm_b : pwm_a;
    endfunction

    // waits for the chosen output to reach lvl; returns cycle or -1 on timeout
    task automatic wait_lvl(input bit b, input logic lvl, output int t);
        int n = 0;
        t = -1;
        while (pick(b) != lvl && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (pick(b) == lvl) t = cyc;
    endtask

    task automatic wait_flip(input bit b, output int t);
        logic prev = pick(b);
        wait_lvl(b, ~prev, t);
    endtask

    task automatic setup(input int ctrl, input int ca, input int cb,
                         input int aa, input int ab, input int prd);
        do_reset();
        wr(3, ctrl); wr(1, ca); wr(2, cb); wr(4, aa); wr(5, ab); wr(0, prd);
    endtask

    task automatic t_reset();
        int ones = 0;
        do_reset();
        chk("R1 pwm_a after reset", pwm_a, 0);
        chk("R1 pwm_b after reset", pwm_b, 0);
        repeat (20) begin @(negedge clk); ones += pwm_a + pwm_b; end
        chk("R1 outputs idle", ones, 0);
    endtask

    task automatic t_symmetric();
        int t0, t1, t2, t3, bad = 0;
        // triangle P=10, A: rise->high, fall->low; B mirrored, both C=4
        setup(1, 4, 4, 4'b0110, 4'b1001, 10);
        wait_lvl(0, 1, t0); wait_lvl(0, 0, t1); wait_lvl(0, 1, t2);
        chk("R9 A high width", t1 - t0, 12);
        chk("R3 triangle period", t2 - t0, 20);
        wait_lvl(1, 1, t0); wait_lvl(1, 0, t3);
        chk("R9 B high width", t3 - t0, 8);
        repeat (60) begin @(negedge clk); if (pwm_a == pwm_b) bad++; end
        chk("R9 B complement of A", bad, 0);
    endtask

    task automatic t_sawtooth();
        int t0, t1;
        setup(0, 2, 0, 4'b0011, 0, 5);
        wait_flip(0, t0); wait_flip(0, t0); wait_flip(0, t1);
        chk("R2 saw-tooth period", t1 - t0, 6);
    endtask

    task automatic t_truncate();
        int t0, t1;
        setup(0, 0, 0, 4'b0011, 0, 32'h0001_0007);
        wait_flip(0, t0); wait_flip(0, t0); wait_flip(0, t1);
        chk("R5 period low 16 bits", t1 - t0, 8);
    endtask

    task automatic t_prescale(input int e1, input int e2);
        int t0, t1;
        setup((e2 << 4) | (e1 << 1), 0, 0, 4'b0011, 0, 3);
        wait_flip(0, t0); wait_flip(0, t0); wait_flip(0, t1);
        chk("R4 divided tick", t1 - t0, 4 * (1 << e1) * (1 << e2));
    endtask

    task automatic t_shadow();
        int t0, t1, t2, t3;
        setup(1, 4, 0, 4'b0110, 0, 10);
        wait_lvl(0, 1, t0);
        wr(1, 2);
        wait_lvl(0, 0, t1); wait_lvl(0, 1, t2); wait_lvl(0, 0, t3);
        chk("R6 pulse in progress unchanged", t1 - t0, 12);
        chk("R6 gap after zero reload", t2 - t1, 6);
        chk("R6 new width applied", t3 - t2, 16);
    endtask

    task automatic t_immediate();
        int t0, t1;
        setup(1 | (1 << 7), 4, 0, 4'b0110, 0, 10);
        wait_lvl(0, 1, t0);
        wr(1, 2);
        wait_lvl(0, 0, t1);
        chk("R7 immediate compare", t1 - t0, 14);
    endtask

    task automatic t_turn(input int c);
        int t0, t1;
        setup(1, c, 0, 4'b1111, 0, 10);
        wait_flip(0, t0); wait_flip(0, t0); wait_flip(0, t1);
        chk("R10 single action at turning point", t1 - t0, 20);
    endtask

    task automatic t_no_action();
        int t0, lows = 0;
        setup(1, 4, 0, 4'b0010, 0, 10);
        wait_lvl(0, 1, t0);
        chk("R8 set code drives high", (t0 > 0) ? 1 : 0, 1);
        repeat (60) begin @(negedge clk); if (!pwm_a) lows++; end
        chk("R8 code 00 leaves output", lows, 0);
    endtask

    initial begin
        wait (cyc > 150000);
        n_fail++;
        $display("FAIL watchdog: got %0d expected <150000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_symmetric();
        t_sawtooth();
        t_truncate();
        t_prescale(0, 0);
        t_prescale(1, 2);
        t_prescale(2, 1);
        t_shadow();
        t_immediate();
        t_turn(0);
        t_turn(10);
        t_no_action();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule